// File: doc/BRIEF.md
# Pipelined 3x3 Colour Matrix

This block converts a stream of three-channel pixels through a programmable 3x3 matrix. Each output channel is the dot product of one matrix row with the three input channels. Before the multiply, each input channel has a signed offset added to it. After the sum, a signed offset is added to each output channel, and the result is rounded once and clamped to the pixel range. Typical uses are RGB-to-YCbCr conversion, range compression and identity pass-through.

Each coefficient is held in a compact floating form: a sign bit, a 3-bit exponent code that selects the binary point, and a 9-bit mantissa. The block normalises every coefficient to one common fixed-point grid and keeps full product precision until the single final rounding step. Software writes a shadow copy of the twelve configuration registers. That copy moves into the working set only on a frame-start strobe, so a frame is always processed with one consistent coefficient set.

Top module: `csc_matrix`

## Requirements
- R1: After reset, `out_valid` is low and `out_pix` is zero. Every shadow and working register holds zero, so any pixel produces an all-zero output.
- R2: A pixel accepted with `in_valid` high appears on `out_pix` with `out_valid` high exactly 3 clock edges later. `out_valid` is never high in any other cycle, and bubbles in `in_valid` are preserved.
- R3: A 16-bit coefficient word is decoded as follows. Bit 15 is the sign (1 = negative). Bits 14:12 are the exponent code. Bits 11:3 are the mantissa m. Bits 2:0 are ignored. The value is ±m/2^f, where codes 3, 2, 1, 0, 7 and 6 give f = 12, 11, 10, 9, 8 and 7.
- R4: Exponent codes 4 and 5 decode to a zero coefficient, whatever the sign and mantissa.
- R5: The register map is as follows.
  - Coefficient k multiplies input channel k mod 3 for output row k/3.
  - Address 2r holds coefficient 3r in bits 31:16 and coefficient 3r+1 in bits 15:0.
  - Address 2r+1 holds coefficient 3r+2 in bits 31:16, and its bits 15:0 are ignored.
  - Addresses 6, 7 and 8 hold the pre-offsets of input channels 0, 1 and 2.
  - Addresses 9, 10 and 11 hold the post-offsets of rows 0 (Y), 1 (U) and 2 (V).
  - Writes to addresses 12 to 15 have no effect.
- R6: A pre-offset is an 11-bit two's-complement value in bits 10:0, in pixel LSBs. It is added to its input channel before the multiply.
- R7: A post-offset is a 13-bit two's-complement value in bits 28:16, in units of 1/4096 of full scale (a quarter of a pixel LSB for 10-bit pixels). It is added to its row sum before rounding. With zero coefficients, post-offsets 0x100, 0x800 and 0x800 produce the output 64, 512, 512.
- R8: The exact row result x is rounded once, to floor(x + 1/2). No intermediate rounding is applied.
- R9: A rounded result below 0 outputs 0, and one above 1023 outputs 1023.
- R10: Register writes change only the shadow copy. A frame-start strobe copies all twelve shadow registers into the working set. Pixels accepted after the strobe edge use the new set. The strobe is issued only while no pixel is in stages 0 to 2.
- R11: Input channel j occupies `in_pix` bits 10j+9:10j. Output row Y occupies `out_pix` bits 9:0, U occupies bits 19:10 and V occupies bits 29:20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 32 | Register write data |
| frame_start | input | 1 | Copies shadow registers to the working set |
| in_valid | input | 1 | Input pixel qualifier |
| in_pix | input | 30 | Three 10-bit input channels |
| out_valid | output | 1 | Output pixel qualifier |
| out_pix | output | 30 | Three 10-bit output channels |

## Verification
The bench sweeps every exponent code with both signs, over edge mantissas and with junk in the ignored low bits. A decoder that mapped a code to the wrong shift would scale outputs by a power of two, and one that treated codes 4 and 5 as valid would leak the mantissa into the result. Half-LSB cases with positive and negative coefficients check rounding: truncation or round-toward-zero would land one code low. Gains near four drive both clamp rails; a missing clamp would wrap the output. Writes made mid-stream without a strobe must leave outputs on the old set, so a bank without a shadow copy would change results inside a frame. A channel permutation and randomised register sets catch swapped halves, wrong row order, and the ignored half-register and out-of-range addresses.

// File: rtl/csc_pkg.sv
package csc_pkg;

    localparam int NCH       = 3;
    localparam int NCOEF     = NCH * NCH;
    localparam int REG_W     = 32;
    localparam int MANT_W    = 9;
    localparam int FRAC_MAX  = 12;              // finest binary point of any exponent code
    localparam int MAX_SHIFT = 5;               // coarsest code sits 5 steps above the finest
    localparam int MAG_W     = MANT_W + MAX_SHIFT;
    localparam int COEF_W    = MAG_W + 1;       // signed, units of 2^-FRAC_MAX
    localparam int POST_FRAC = 12;              // post-offset is in 1/4096 of full scale
    localparam int POST_LSB  = 16;              // post-offset field position in its register
    localparam int PRE_BASE  = 6;
    localparam int POST_BASE = 9;

    typedef enum logic [2:0] {
        EXP_F9    = 3'd0,
        EXP_F10   = 3'd1,
        EXP_F11   = 3'd2,
        EXP_F12   = 3'd3,
        EXP_RSV_A = 3'd4,
        EXP_RSV_B = 3'd5,
        EXP_F7    = 3'd6,
        EXP_F8    = 3'd7
    } exp_code_e;

    // Stored coefficient: the three low bits of the written word are dropped.
    typedef struct packed {
        logic             neg;
        exp_code_e        code;
        logic [MANT_W-1:0] mant;
    } coef_field_t;

    localparam int FIELD_W = $bits(coef_field_t);

    function automatic logic signed [COEF_W-1:0] decode_coef(input coef_field_t f);
        logic [MAG_W-1:0]  mag;
        logic [COEF_W-1:0] pos;
        case (f.code)
            EXP_F12: mag = MAG_W'(f.mant);
            EXP_F11: mag = MAG_W'(f.mant) << 1;
            EXP_F10: mag = MAG_W'(f.mant) << 2;
            EXP_F9:  mag = MAG_W'(f.mant) << 3;
            EXP_F8:  mag = MAG_W'(f.mant) << 4;
            EXP_F7:  mag = MAG_W'(f.mant) << 5;
            default: mag = '0;
        endcase
        pos = {1'b0, mag};
        return f.neg ? -$signed(pos) : $signed(pos);
    endfunction

endpackage

// File: rtl/csc_reg_bank.sv
module csc_reg_bank
    import csc_pkg::*;
#(
    parameter int PIX_W  = 10,
    parameter int POST_W = 13,
    parameter int ADDR_W = 4
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [REG_W-1:0]                  wr_data,
    input  logic                              frame_start,
    output coef_field_t [NCOEF-1:0]           act_coef,
    output logic [NCH-1:0][PIX_W:0]           act_pre,
    output logic [NCH-1:0][POST_W-1:0]        act_post
);
    localparam int PRE_W = PIX_W + 1;

    coef_field_t [NCOEF-1:0]    sh_coef;
    logic [NCH-1:0][PRE_W-1:0]  sh_pre;
    logic [NCH-1:0][POST_W-1:0] sh_post;

    // Shadow copy: software writes land here only.
    always_ff @(posedge clk) begin
        if (rst) begin
            sh_coef <= '0;
            sh_pre  <= '0;
            sh_post <= '0;
        end else if (wr_en) begin
            for (int r = 0; r < NCH; r++) begin
                if (wr_addr == ADDR_W'(2 * r)) begin
                    sh_coef[3*r]   <= coef_field_t'(wr_data[REG_W-1 -: FIELD_W]);
                    sh_coef[3*r+1] <= coef_field_t'(wr_data[REG_W/2-1 -: FIELD_W]);
                end
                if (wr_addr == ADDR_W'(2 * r + 1))
                    sh_coef[3*r+2] <= coef_field_t'(wr_data[REG_W-1 -: FIELD_W]);
                if (wr_addr == ADDR_W'(PRE_BASE + r))
                    sh_pre[r] <= wr_data[PRE_W-1:0];
                if (wr_addr == ADDR_W'(POST_BASE + r))
                    sh_post[r] <= wr_data[POST_LSB +: POST_W];
            end
        end
    end

    // Working set: moves only on the frame strobe.
    always_ff @(posedge clk) begin
        if (rst) begin
            act_coef <= '0;
            act_pre  <= '0;
            act_post <= '0;
        end else if (frame_start) begin
            act_coef <= sh_coef;
            act_pre  <= sh_pre;
            act_post <= sh_post;
        end
    end

    assert_hold_between_frames_R10: assert property (@(posedge clk) disable iff (rst)
        !frame_start |=> ($stable(act_coef) && $stable(act_pre) && $stable(act_post)));

    assert_commit_copies_shadow_R10: assert property (@(posedge clk) disable iff (rst)
        frame_start |=> (act_coef == $past(sh_coef) && act_pre == $past(sh_pre)
                         && act_post == $past(sh_post)));

endmodule

// File: rtl/csc_coef_decode.sv
module csc_coef_decode
    import csc_pkg::*;
(
    input  coef_field_t [NCOEF-1:0]        raw,
    output logic [NCOEF-1:0][COEF_W-1:0]   val
);
    for (genvar k = 0; k < NCOEF; k++) begin : g_dec
        assign val[k] = decode_coef(raw[k]);
    end
endmodule

// File: rtl/csc_row.sv
module csc_row
    import csc_pkg::*;
#(
    parameter int PIX_W  = 10,
    parameter int POST_W = 13
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            v1,
    input  logic                            v2,
    input  logic [NCH-1:0][PIX_W+1:0]       adj,
    input  logic [NCH-1:0][COEF_W-1:0]      coef,
    input  logic [POST_W-1:0]               post,
    output logic [PIX_W-1:0]                pix
);
    localparam int    A_W     = PIX_W + 2;
    localparam int    PROD_W  = A_W + COEF_W;
    localparam int    ACC_W   = PROD_W + 3;
    localparam int    POST_SH = PIX_W + FRAC_MAX - POST_FRAC;
    localparam longint HALF   = 64'sd1 <<< (FRAC_MAX - 1);
    localparam int    PIX_MAX = (1 << PIX_W) - 1;

    logic [NCH-1:0][PROD_W-1:0] prod_q;
    logic signed [ACC_W-1:0]    post_term;
    logic signed [ACC_W-1:0]    sum;
    logic signed [ACC_W-1:0]    rnd;
    logic                       hi_sat;
    logic                       lo_sat;

    // Stage 2: full-width products.
    always_ff @(posedge clk) begin
        if (rst) begin
            prod_q <= '0;
        end else if (v1) begin
            for (int j = 0; j < NCH; j++)
                prod_q[j] <= PROD_W'($signed(adj[j])) * PROD_W'($signed(coef[j]));
        end
    end

    // Stage 3: sum, post-offset, single rounding, clamp.
    always_comb begin
        post_term = ACC_W'($signed(post)) <<< POST_SH;
        sum       = ACC_W'(HALF) + post_term;
        for (int j = 0; j < NCH; j++)
            sum = sum + ACC_W'($signed(prod_q[j]));
        rnd = sum >>> FRAC_MAX;
    end

    assign lo_sat = (rnd < 0);
    assign hi_sat = (rnd > ACC_W'(PIX_MAX));

    always_ff @(posedge clk) begin
        if (rst)
            pix <= '0;
        else if (v2)
            pix <= lo_sat ? '0 : (hi_sat ? PIX_W'(PIX_MAX) : rnd[PIX_W-1:0]);
    end

    assert_clamp_top_R9: assert property (@(posedge clk) disable iff (rst)
        (v2 && hi_sat) |=> (pix == PIX_W'(PIX_MAX)));

    assert_clamp_bottom_R9: assert property (@(posedge clk) disable iff (rst)
        (v2 && lo_sat) |=> (pix == '0));

endmodule

// File: rtl/csc_matrix.sv
module csc_matrix
    import csc_pkg::*;
#(
    parameter int PIX_W  = 10,
    parameter int POST_W = 13,
    parameter int ADDR_W = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [31:0]            wr_data,
    input  logic                   frame_start,
    input  logic                   in_valid,
    input  logic [3*PIX_W-1:0]     in_pix,
    output logic                   out_valid,
    output logic [3*PIX_W-1:0]     out_pix
);
    localparam int A_W = PIX_W + 2;

    coef_field_t [NCOEF-1:0]          act_coef;
    logic [NCH-1:0][PIX_W:0]          act_pre;
    logic [NCH-1:0][POST_W-1:0]       act_post;
    logic [NCOEF-1:0][COEF_W-1:0]     coef_dec;
    logic [NCH-1:0][A_W-1:0]          adj_q;
    logic                             v1, v2, v3;
    logic [1:0]                       warm;

    csc_reg_bank #(.PIX_W(PIX_W), .POST_W(POST_W), .ADDR_W(ADDR_W)) u_bank (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .frame_start (frame_start),
        .act_coef    (act_coef),
        .act_pre     (act_pre),
        .act_post    (act_post)
    );

    csc_coef_decode u_dec (
        .raw (act_coef),
        .val (coef_dec)
    );

    // Stage 1: pre-offset adjust per input channel.
    always_ff @(posedge clk) begin
        if (rst) begin
            adj_q <= '0;
        end else if (in_valid) begin
            for (int j = 0; j < NCH; j++)
                adj_q[j] <= A_W'($signed({1'b0, in_pix[j*PIX_W +: PIX_W]}))
                          + A_W'($signed(act_pre[j]));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v1 <= 1'b0;
            v2 <= 1'b0;
            v3 <= 1'b0;
        end else begin
            v1 <= in_valid;
            v2 <= v1;
            v3 <= v2;
        end
    end

    for (genvar r = 0; r < NCH; r++) begin : g_row
        csc_row #(.PIX_W(PIX_W), .POST_W(POST_W)) u_row (
            .clk  (clk),
            .rst  (rst),
            .v1   (v1),
            .v2   (v2),
            .adj  (adj_q),
            .coef (coef_dec[3*r +: 3]),
            .post (act_post[r]),
            .pix  (out_pix[r*PIX_W +: PIX_W])
        );
    end

    assign out_valid = v3;

    // Cycles since reset, so the latency check never reaches before it.
    always_ff @(posedge clk) begin
        if (rst)
            warm <= '0;
        else if (warm != 2'd3)
            warm <= warm + 2'd1;
    end

    assert_latency_three_R2: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    assert_commit_idle_R10: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> (!in_valid && !v1 && !v2));

endmodule

// File: tb/csc_matrix_tb.sv
module csc_matrix_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        frame_start = 1'b0;
    logic        in_valid = 1'b0;
    logic [29:0] in_pix = '0;
    logic        out_valid;
    logic [29:0] out_pix;

    int     nchk = 0;
    int     nerr = 0;
    longint cyc  = 0;
    bit     done = 1'b0;

    logic [15:0] sh_c [9];
    logic [15:0] act_c[9];
    logic [10:0] sh_pre[3];
    logic [10:0] act_pre[3];
    logic [12:0] sh_post[3];
    logic [12:0] act_post[3];
    logic [15:0] stage_c[9];

    longint      exp_cyc[$];
    logic [29:0] exp_pix[$];
    string       exp_tag[$];

    csc_matrix u_dut (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .frame_start (frame_start),
        .in_valid    (in_valid),
        .in_pix      (in_pix),
        .out_valid   (out_valid),
        .out_pix     (out_pix)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] enc(bit neg, logic [2:0] code, logic [8:0] mant, logic [2:0] junk);
        return {neg, code, mant, junk};
    endfunction

    // Coefficient value in units of 2^-12 (R3, R4).
    function automatic longint coef_val(logic [15:0] raw);
        int f;
        longint m;
        case (raw[14:12])
            3'd3: f = 12;
            3'd2: f = 11;
            3'd1: f = 10;
            3'd0: f = 9;
            3'd7: f = 8;
            3'd6: f = 7;
            default: f = -1;
        endcase
        if (f < 0) return 0;
        m = longint'(raw[11:3]) << (12 - f);
        return raw[15] ? -m : m;
    endfunction

    function automatic logic [29:0] model_pix(logic [29:0] p);
        logic [29:0] res;
        longint acc;
        res = '0;
        for (int row = 0; row < 3; row++) begin
            acc = 0;
            for (int j = 0; j < 3; j++)
                acc += (longint'(p[j*10 +: 10]) + longint'($signed(act_pre[j])))
                       * coef_val(act_c[row*3 + j]);
            acc += longint'($signed(act_post[row])) * 1024 + 2048;
            acc = acc >>> 12;
            if (acc < 0) acc = 0;
            if (acc > 1023) acc = 1023;
            res[row*10 +: 10] = acc[9:0];
        end
        return res;
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] got, logic [31:0] expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: got %h expected %h", tag, got, expv);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (exp_cyc.size() > 0 && exp_cyc[0] == cyc) begin
                check(out_valid === 1'b1 && out_pix === exp_pix[0], exp_tag[0],
                      {1'b0, out_valid, out_pix}, {2'b01, exp_pix[0]});
                void'(exp_cyc.pop_front());
                void'(exp_pix.pop_front());
                void'(exp_tag.pop_front());
            end else if (out_valid !== 1'b0) begin
                check(1'b0, "R2 unexpected out_valid", 32'(out_valid), 32'd0);
            end
        end
    end

    task automatic idle(int n);
        repeat (n) begin
            @(negedge clk);
            in_valid = 1'b0;
            wr_en    = 1'b0;
            frame_start = 1'b0;
        end
    endtask

    task automatic push(logic [29:0] p, string tag);
        @(negedge clk);
        wr_en    = 1'b0;
        in_valid = 1'b1;
        in_pix   = p;
        exp_cyc.push_back(cyc + 3);
        exp_pix.push_back(model_pix(p));
        exp_tag.push_back(tag);
    endtask

    // Register write, model follows the map of R5, R6, R7.
    task automatic wr(logic [3:0] a, logic [31:0] d);
        @(negedge clk);
        in_valid = 1'b0;
        wr_en    = 1'b1;
        wr_addr  = a;
        wr_data  = d;
        case (a)
            4'd0: begin sh_c[0] = d[31:16]; sh_c[1] = d[15:0]; end
            4'd1: sh_c[2] = d[31:16];
            4'd2: begin sh_c[3] = d[31:16]; sh_c[4] = d[15:0]; end
            4'd3: sh_c[5] = d[31:16];
            4'd4: begin sh_c[6] = d[31:16]; sh_c[7] = d[15:0]; end
            4'd5: sh_c[8] = d[31:16];
            4'd6, 4'd7, 4'd8: sh_pre[a - 6] = d[10:0];
            4'd9, 4'd10, 4'd11: sh_post[a - 9] = d[28:16];
            default: ;
        endcase
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_coefs(logic [15:0] junk);
        for (int r = 0; r < 3; r++) begin
            wr(4'(2*r), {stage_c[3*r], stage_c[3*r+1]});
            wr(4'(2*r+1), {stage_c[3*r+2], junk});
        end
    endtask

    task automatic load_offs(logic [10:0] p0, logic [10:0] p1, logic [10:0] p2,
                             logic [12:0] q0, logic [12:0] q1, logic [12:0] q2);
        wr(4'd6, {21'd0, p0});
        wr(4'd7, {21'd0, p1});
        wr(4'd8, {21'd0, p2});
        wr(4'd9,  {3'd0, q0, 16'd0});
        wr(4'd10, {3'd0, q1, 16'd0});
        wr(4'd11, {3'd0, q2, 16'd0});
    endtask

    task automatic commit();
        idle(4);
        @(negedge clk);
        frame_start = 1'b1;
        for (int k = 0; k < 9; k++) act_c[k] = sh_c[k];
        for (int k = 0; k < 3; k++) begin
            act_pre[k]  = sh_pre[k];
            act_post[k] = sh_post[k];
        end
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic diag(logic [15:0] c);
        for (int k = 0; k < 9; k++) stage_c[k] = 16'd0;
        stage_c[0] = c;
        stage_c[4] = c;
        stage_c[8] = c;
    endtask

    function automatic logic [29:0] px(int a, int b, int c);
        return {10'(c), 10'(b), 10'(a)};
    endfunction

    initial begin
        for (int k = 0; k < 9; k++) begin sh_c[k] = '0; act_c[k] = '0; end
        for (int k = 0; k < 3; k++) begin
            sh_pre[k] = '0; act_pre[k] = '0; sh_post[k] = '0; act_post[k] = '0;
        end
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        check(out_valid === 1'b0 && out_pix === 30'd0, "R1 reset outputs",
              {1'b0, out_valid, out_pix}, 32'd0);
        push(px(1023, 512, 7), "R1 zero registers");
        idle(5);

        // R2: bubbles in the valid stream
        diag(enc(0, 3'd7, 9'd256, 3'd0));
        load_coefs(16'h0);
        commit();
        push(px(10, 20, 30), "R2");
        idle(1);
        push(px(40, 50, 60), "R2");
        push(px(70, 80, 90), "R2");
        idle(2);
        push(px(1, 2, 3), "R2");
        idle(5);

        // R3: every exponent code, both signs, edge mantissas, junk low bits
        load_offs(11'd0, 11'd0, 11'd0, 13'h800, 13'h800, 13'h800);
        begin
            int codes[6] = '{3, 2, 1, 0, 7, 6};
            int mants[6] = '{0, 1, 85, 256, 341, 511};
            for (int ci = 0; ci < 6; ci++)
                for (int s = 0; s < 2; s++)
                    for (int mi = 0; mi < 6; mi++) begin
                        diag(enc(s[0], 3'(codes[ci]), 9'(mants[mi]), 3'b101));
                        load_coefs(16'h0);
                        commit();
                        push(px(0, 1023, 500), "R3");
                        push(px(1023, 77, 0), "R3");
                        push(px(500, 0, 1023), "R3");
                        push(px(77, 500, 77), "R3");
                    end
        end

        // R4: reserved exponent codes decode to zero
        for (int c = 4; c < 6; c++)
            for (int s = 0; s < 2; s++) begin
                diag(enc(s[0], 3'(c), 9'd511, 3'd7));
                load_coefs(16'h0);
                commit();
                push(px(1023, 1023, 1023), "R4");
                push(px(300, 600, 900), "R4");
            end

        // R6: pre-offsets, positive and negative, with unity gain
        diag(enc(0, 3'd7, 9'd256, 3'd0));
        load_coefs(16'h0);
        load_offs(11'h79C, 11'd300, 11'h400, 13'd0, 13'd0, 13'd0);
        commit();
        for (int v = 0; v < 1024; v += 31) push(px(v, 1023 - v, v), "R6");

        // R7: chroma/luma preset offsets and a negative post-offset
        diag(16'd0);
        load_coefs(16'h0);
        load_offs(11'd0, 11'd0, 11'd0, 13'h100, 13'h800, 13'h800);
        commit();
        push(px(123, 456, 789), "R7 preset");
        idle(4);
        check(1'b1, "R7", 0, 0);
        diag(enc(0, 3'd7, 9'd256, 3'd0));
        load_coefs(16'h0);
        load_offs(11'd0, 11'd0, 11'd0, 13'h1F00, 13'h1FFF, 13'h0FFF);
        commit();
        for (int v = 0; v < 1024; v += 97) push(px(v, v, v), "R7");

        // R8: half-LSB ties with positive and negative coefficients
        diag(enc(0, 3'd0, 9'd256, 3'd0));
        load_coefs(16'h0);
        load_offs(11'd0, 11'd0, 11'd0, 13'd0, 13'd0, 13'd0);
        commit();
        for (int v = 1; v < 40; v += 2) push(px(v, v + 2, v + 4), "R8");
        diag(enc(1, 3'd1, 9'd256, 3'd0));
        load_coefs(16'h0);
        load_offs(11'd0, 11'd0, 11'd0, 13'h800, 13'h801, 13'h802);
        commit();
        for (int v = 1; v < 30; v++) push(px(v, v, v), "R8");

        // R9: gains near four drive both rails
        diag(enc(0, 3'd6, 9'd511, 3'd0));
        load_coefs(16'h0);
        load_offs(11'd0, 11'd0, 11'd0, 13'd0, 13'd0, 13'd0);
        commit();
        for (int v = 0; v < 1024; v += 63) push(px(v, 1023 - v, v / 2), "R9");
        diag(enc(1, 3'd6, 9'd511, 3'd0));
        load_coefs(16'h0);
        load_offs(11'd0, 11'd0, 11'd0, 13'h800, 13'h800, 13'h800);
        commit();
        for (int v = 0; v < 1024; v += 63) push(px(v, 1023 - v, v / 2), "R9");

        // R10: shadow writes stay invisible until the strobe
        diag(enc(0, 3'd7, 9'd256, 3'd0));
        load_coefs(16'h0);
        load_offs(11'd0, 11'd0, 11'd0, 13'd0, 13'd0, 13'd0);
        commit();
        push(px(100, 200, 300), "R10 before");
        diag(enc(0, 3'd0, 9'd256, 3'd0));
        wr(4'd0, {stage_c[0], stage_c[1]});
        push(px(101, 201, 301), "R10 shadow only");
        wr(4'd2, {stage_c[3], stage_c[4]});
        wr(4'd9, {3'd0, 13'h400, 16'd0});
        push(px(102, 202, 302), "R10 shadow only");
        load_coefs(16'h0);
        push(px(103, 203, 303), "R10 shadow only");
        commit();
        push(px(104, 204, 304), "R10 after strobe");
        push(px(1023, 1023, 1023), "R10 after strobe");

        // R11: channel permutation exposes packing
        for (int k = 0; k < 9; k++) stage_c[k] = 16'd0;
        stage_c[2] = enc(0, 3'd7, 9'd256, 3'd0);
        stage_c[3] = enc(0, 3'd7, 9'd256, 3'd0);
        stage_c[7] = enc(0, 3'd7, 9'd256, 3'd0);
        load_coefs(16'h0);
        load_offs(11'd0, 11'd0, 11'd0, 13'd0, 13'd0, 13'd0);
        commit();
        push(px(11, 522, 1000), "R11");
        push(px(1023, 0, 300), "R11");

        // R5: randomised full register sets, junk halves, dead addresses
        for (int t = 0; t < 150; t++) begin
            for (int k = 0; k < 9; k++) stage_c[k] = 16'($urandom);
            load_coefs(16'($urandom));
            load_offs(11'($urandom), 11'($urandom), 11'($urandom),
                      13'($urandom), 13'($urandom), 13'($urandom));
            wr(4'(12 + (t % 4)), $urandom);
            commit();
            for (int p = 0; p < 12; p++) push(30'($urandom), "R5");
        end

        idle(6);
        check(exp_cyc.size() == 0, "R2 all outputs delivered", 32'(exp_cyc.size()), 32'd0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL R2 watchdog expired: got %0d expected 0 pending", exp_cyc.size());
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

endmodule